// File: doc/BRIEF.md
# Drive Register Bus Cycle Engine

This block turns single register requests from a host into complete read or write cycles on a parallel disk-drive register bus. The host presents a register bank (main or auxiliary), a three-bit register index, a direction and write data, and holds the request until the engine pulses `rsp_done`. The engine then drives the matching active-low chip select and address lines. It waits a setup interval, asserts the read or write strobe for a minimum width, and keeps chip select and address driven for a hold interval after the strobe rises. It then reports completion and, for a read, the captured data.

The engine owns the drive-side data bus as split input, output and output-enable signals. Only the data register (main bank, index 0) moves 16 bits. Every other register moves bits 7..0. Write data for those registers goes out with the upper byte at zero, and read data comes back with the upper byte cleared. Timing comes from parameters in picoseconds together with the clock period. Each interval is rounded up to whole clocks, with a floor of one clock, so no minimum is ever undercut.

The engine is a state machine with five named states. IDLE waits for a request. SETUP drives chip select and address with both strobes high. STROBE holds one strobe low. HOLD keeps chip select and address after the strobe is released. FINISH pulses done with chip selects released. The transitions are:
- IDLE to SETUP on a valid request.
- IDLE to FINISH on a request for a register that does not exist.
- SETUP to STROBE when the setup count expires.
- STROBE to HOLD when the width count expires. The read data is captured on this transition.
- HOLD to FINISH when the hold count expires.
- FINISH to IDLE unconditionally.

Top module: `drive_bus_cycler`

## Requirements
- R1: While reset is held, and after it, until a request arrives, both chip selects and both strobes are high, the data output enable is low and `rsp_done` is low.
- R2: A main-bank request (`req_aux`=0) drives `drv_cs0_n`=0 and `drv_cs1_n`=1, with `drv_addr` equal to the register index, for the whole cycle. Address and chip select do not change while chip select is active.
- R3: An auxiliary-bank request (`req_aux`=1) to index 6 (read or write), or a read of index 7, drives `drv_cs1_n`=0 and `drv_cs0_n`=1, with `drv_addr` equal to the index.
- R4: Any other auxiliary request (indices 0..5, or a write to 7) produces no chip select and no strobe. It completes with `rsp_done` and `rsp_err`=1 on the clock after acceptance, and `rsp_rdata`=0. Valid requests complete with `rsp_err`=0.
- R5: Chip select and address are active, with both strobes high, for exactly SETUP_CYC = max(1, ceil(SETUP_PS/CLK_PERIOD_PS)) clocks before the strobe falls. The defaults give 2 clocks.
- R6: Exactly one strobe is asserted per cycle: `drv_rd_n` for reads, `drv_wr_n` for writes. It stays low for exactly STROBE_CYC = max(1, ceil(STROBE_PS/CLK_PERIOD_PS)) consecutive clocks. The defaults give 4.
- R7: After the strobe rises, chip select and address stay active for exactly HOLD_CYC = max(1, ceil(HOLD_PS/CLK_PERIOD_PS)) clocks (default 1), and are then released.
- R8: During a write, `drv_data_oe` is 1 for every clock that chip select is active, and `drv_data_out` stays stable through the strobe. The data register drives all 16 bits of `req_wdata`. Other registers drive {8'h00, `req_wdata`[7:0]}.
- R9: During a read, `drv_data_oe` stays 0. `drv_data_in` is sampled on the last clock of the strobe. `rsp_rdata` is the full word for the data register and {8'h00, low byte} for all other registers.
- R10: `rsp_done` is a one-clock pulse that follows the last hold clock. The request fields are latched at acceptance, so changes to them during the cycle have no effect on the bus. A request is accepted only from IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `rsp_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_aux | input | 1 | 0 = main bank, 1 = auxiliary bank |
| req_addr | input | 3 | Register index within the bank |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Request named a nonexistent register |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| drv_cs0_n | output | 1 | Main-bank select, active low |
| drv_cs1_n | output | 1 | Auxiliary-bank select, active low |
| drv_addr | output | 3 | Register address lines |
| drv_rd_n | output | 1 | Read strobe, active low |
| drv_wr_n | output | 1 | Write strobe, active low; data taken on its rising edge |
| drv_data_in | input | 16 | Data from the drive |
| drv_data_out | output | 16 | Data to the drive |
| drv_data_oe | output | 1 | Output enable for `drv_data_out` |

## Verification
The bench sweeps every bank, index and direction. For each cycle it counts the setup, strobe and hold clocks at the pins, and compares them with figures it computes from the picosecond parameters.

It targets several corner cases:
- Off-by-one phase counters. These would show up as a setup, strobe or hold length that is one clock short or long.
- A capture taken a clock late. The bench model drives a poison word whenever the read strobe is high, so a late capture returns that word instead of the register pattern.
- Width handling. A design that forgot to narrow non-data registers would put write data on the upper byte or return it in read data.
- Bad decoding. An auxiliary decode that accepted indices 0..5, or a write to index 7, would show a chip select or strobe where none may appear.
- Not latching the request. The bench rewrites the request fields partway through each cycle, so an unlatched request would move the address or data mid-cycle.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_FINISH = 3'd4
    } cyc_state_t;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int NARROW_W = 8;

    function automatic int cycles_for(input int span_ps, input int clk_ps);
        int raw;
        raw = (span_ps + clk_ps - 1) / clk_ps;
        return (raw < 1) ? 1 : raw;
    endfunction

endpackage

// File: rtl/dbc_decode.sv
module dbc_decode
    import dbc_pkg::*;
(
    input  logic              aux,
    input  logic              write,
    input  logic [ADDR_W-1:0] index,
    output logic              legal,
    output logic              wide
);
    localparam logic [ADDR_W-1:0] IDX_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] IDX_AUX_CTRL = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] IDX_AUX_ECHO = ADDR_W'(7);

    always_comb begin
        if (!aux) begin
            legal = 1'b1;
            wide  = (index == IDX_DATA);
        end else begin
            legal = (index == IDX_AUX_CTRL) || ((index == IDX_AUX_ECHO) && !write);
            wide  = 1'b0;
        end
    end
endmodule

// File: rtl/dbc_timer.sv
module dbc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/drive_bus_cycler.sv
module drive_bus_cycler
    import dbc_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int SETUP_PS      = 25000,
    parameter int STROBE_PS     = 80000,
    parameter int HOLD_PS       = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_aux,
    input  logic [2:0]        req_addr,
    input  logic [15:0]       req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [15:0]       rsp_rdata,
    output logic              drv_cs0_n,
    output logic              drv_cs1_n,
    output logic [2:0]        drv_addr,
    output logic              drv_rd_n,
    output logic              drv_wr_n,
    input  logic [15:0]       drv_data_in,
    output logic [15:0]       drv_data_out,
    output logic              drv_data_oe
);
    localparam int SETUP_CYC  = cycles_for(SETUP_PS, CLK_PERIOD_PS);
    localparam int STROBE_CYC = cycles_for(STROBE_PS, CLK_PERIOD_PS);
    localparam int HOLD_CYC   = cycles_for(HOLD_PS, CLK_PERIOD_PS);
    localparam int MAX_CYC    = (SETUP_CYC > STROBE_CYC)
                              ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                              : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

    cyc_state_t state_q, state_d;

    logic              dec_legal, dec_wide;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;

    logic              lat_write, lat_aux, lat_wide;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              bus_active;

    dbc_decode u_decode (
        .aux   (req_aux),
        .write (req_write),
        .index (req_addr),
        .legal (dec_legal),
        .wide  (dec_wide)
    );

    dbc_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_legal) begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LD;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = STROBE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Request latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_aux   <= 1'b0;
            lat_wide  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rdata_q   <= '0;
            err_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                lat_write <= req_write;
                lat_aux   <= req_aux;
                lat_wide  <= dec_wide;
                lat_addr  <= req_addr;
                lat_wdata <= dec_wide ? req_wdata
                                      : {{(DATA_W-NARROW_W){1'b0}}, req_wdata[NARROW_W-1:0]};
                rdata_q   <= '0;
                err_q     <= !dec_legal;
            end else if (state_q == ST_STROBE && tmr_expired && !lat_write) begin
                rdata_q <= lat_wide ? drv_data_in
                                    : {{(DATA_W-NARROW_W){1'b0}}, drv_data_in[NARROW_W-1:0]};
            end
        end
    end

    // Outputs
    always_comb begin
        bus_active   = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        drv_cs0_n    = !(bus_active && !lat_aux);
        drv_cs1_n    = !(bus_active && lat_aux);
        drv_addr     = lat_addr;
        drv_rd_n     = !((state_q == ST_STROBE) && !lat_write);
        drv_wr_n     = !((state_q == ST_STROBE) && lat_write);
        drv_data_oe  = bus_active && lat_write;
        drv_data_out = lat_wdata;
        rsp_done     = (state_q == ST_FINISH);
        rsp_err      = err_q;
        rsp_rdata    = rdata_q;
    end
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker
    import dbc_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int SETUP_PS      = 25000,
    parameter int STROBE_PS     = 80000,
    parameter int HOLD_PS       = 10000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rsp_done,
    input logic        drv_cs0_n,
    input logic        drv_cs1_n,
    input logic [2:0]  drv_addr,
    input logic        drv_rd_n,
    input logic        drv_wr_n,
    input logic [15:0] drv_data_out,
    input logic        drv_data_oe
);
    localparam int SETUP_CYC  = cycles_for(SETUP_PS, CLK_PERIOD_PS);
    localparam int STROBE_CYC = cycles_for(STROBE_PS, CLK_PERIOD_PS);

    logic cs_on, stb_n;
    logic [15:0] low_run, setup_run;

    assign cs_on = !drv_cs0_n || !drv_cs1_n;
    assign stb_n = drv_rd_n && drv_wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= '0;
            setup_run <= '0;
        end else begin
            low_run   <= stb_n ? 16'd0 : low_run + 16'd1;
            setup_run <= (cs_on && stb_n) ? setup_run + 16'd1 : 16'd0;
        end
    end

    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!drv_cs0_n && !drv_cs1_n));

    assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_on && $past(cs_on)) |-> $stable(drv_addr));

    assert_strobe_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_n) |-> (setup_run == 16'(SETUP_CYC)));

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!drv_rd_n && !drv_wr_n));

    assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_n) |-> (low_run == 16'(STROBE_CYC)));

    assert_strobe_in_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |-> cs_on);

    assert_select_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_n) |-> cs_on);

    assert_wdata_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_wr_n && $past(!drv_wr_n)) |-> ($stable(drv_data_out) && drv_data_oe));

    assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_rd_n |-> !drv_data_oe);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!cs_on && stb_n));
endmodule

bind drive_bus_cycler dbc_checker #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .SETUP_PS      (SETUP_PS),
    .STROBE_PS     (STROBE_PS),
    .HOLD_PS       (HOLD_PS)
) u_dbc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rsp_done     (rsp_done),
    .drv_cs0_n    (drv_cs0_n),
    .drv_cs1_n    (drv_cs1_n),
    .drv_addr     (drv_addr),
    .drv_rd_n     (drv_rd_n),
    .drv_wr_n     (drv_wr_n),
    .drv_data_out (drv_data_out),
    .drv_data_oe  (drv_data_oe)
);

// File: tb/tb_drive_bus_cycler.sv
`timescale 1ns/1ps
module tb_drive_bus_cycler;
    localparam int CLK_PS    = 20000;
    localparam int SETUP_PS  = 25000;
    localparam int STROBE_PS = 80000;
    localparam int HOLD_PS   = 10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_aux = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        drv_cs0_n, drv_cs1_n, drv_rd_n, drv_wr_n, drv_data_oe;
    logic [2:0]  drv_addr;
    logic [15:0] drv_data_in, drv_data_out;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    drive_bus_cycler #(
        .CLK_PERIOD_PS(CLK_PS), .SETUP_PS(SETUP_PS),
        .STROBE_PS(STROBE_PS), .HOLD_PS(HOLD_PS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_aux(req_aux), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .drv_cs0_n(drv_cs0_n), .drv_cs1_n(drv_cs1_n), .drv_addr(drv_addr),
        .drv_rd_n(drv_rd_n), .drv_wr_n(drv_wr_n), .drv_data_in(drv_data_in),
        .drv_data_out(drv_data_out), .drv_data_oe(drv_data_oe)
    );

    function automatic int ceil_cyc(input int ps);
        int r;
        r = (ps + CLK_PS - 1) / CLK_PS;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic logic [15:0] pattern(input logic aux, input logic [2:0] a);
        return 16'h9C30 + 16'(a) * 16'h1111 + (aux ? 16'h0808 : 16'h0000);
    endfunction

    // Drive model: valid data only while the read strobe is low, poison otherwise
    assign drv_data_in = drv_rd_n ? 16'hDEAD : pattern(!drv_cs1_n, drv_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cycle(input logic w, input logic aux, input logic [2:0] a,
                             input logic [15:0] wd);
        int setup_n = 0, strobe_n = 0, hold_n = 0, iter = 0;
        bit seen_strobe = 0, seen_done = 0;
        bit bad_cs = 0, bad_addr = 0, bad_strobe = 0, bad_oe = 0, bad_wd = 0;
        bit legal;
        logic [15:0] exp_wd, exp_rd, last_wd;
        legal  = !aux || (a == 3'd6) || (a == 3'd7 && !w);
        exp_wd = (!aux && a == 3'd0) ? wd : {8'h00, wd[7:0]};
        exp_rd = !legal || w ? 16'h0000
               : ((!aux && a == 3'd0) ? pattern(aux, a) : {8'h00, pattern(aux, a)[7:0]});
        last_wd = 16'h0000;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_aux = aux; req_addr = a; req_wdata = wd;
        while (!seen_done && iter < 100) begin
            @(negedge clk);
            iter++;
            if (iter == 2) begin
                req_addr  = ~a;
                req_wdata = ~wd;
            end
            if (!drv_cs0_n || !drv_cs1_n) begin
                if (drv_cs0_n != aux || drv_cs1_n != !aux) bad_cs = 1;
                if (drv_addr != a) bad_addr = 1;
                if (drv_data_oe != w) bad_oe = 1;
                if (w && drv_data_out != exp_wd) bad_wd = 1;
                if (!drv_rd_n || !drv_wr_n) begin
                    strobe_n++;
                    seen_strobe = 1;
                    if (w ? !drv_rd_n : !drv_wr_n) bad_strobe = 1;
                    if (!drv_wr_n) last_wd = drv_data_out;
                end else if (seen_strobe) hold_n++;
                else setup_n++;
            end else begin
                if (!drv_rd_n || !drv_wr_n) bad_strobe = 1;
                if (drv_data_oe) bad_oe = 1;
            end
            if (rsp_done) seen_done = 1;
        end
        req_valid = 1'b0;
        check(seen_done, "R10", "done seen", int'(seen_done), 1);
        check(rsp_err == !legal, "R4", "error flag", int'(rsp_err), int'(!legal));
        check(!bad_cs, legal ? (aux ? "R3" : "R2") : "R4", "chip select decode",
              int'(bad_cs), 0);
        check(!bad_addr, "R10", "address latched", int'(bad_addr), 0);
        check(setup_n == (legal ? ceil_cyc(SETUP_PS) : 0), "R5", "setup clocks",
              setup_n, legal ? ceil_cyc(SETUP_PS) : 0);
        check(strobe_n == (legal ? ceil_cyc(STROBE_PS) : 0), "R6", "strobe clocks",
              strobe_n, legal ? ceil_cyc(STROBE_PS) : 0);
        check(!bad_strobe, "R6", "strobe selection", int'(bad_strobe), 0);
        check(hold_n == (legal ? ceil_cyc(HOLD_PS) : 0), "R7", "hold clocks",
              hold_n, legal ? ceil_cyc(HOLD_PS) : 0);
        check(!bad_oe, w ? "R8" : "R9", "output enable", int'(bad_oe), 0);
        if (w && legal) begin
            check(!bad_wd && last_wd == exp_wd, "R8", "write data", int'(last_wd), int'(exp_wd));
        end
        check(rsp_rdata == exp_rd, w ? "R4" : "R9", "read data", int'(rsp_rdata), int'(exp_rd));
        @(negedge clk);
        check(!rsp_done, "R10", "done one clock", int'(rsp_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(drv_cs0_n && drv_cs1_n && drv_rd_n && drv_wr_n && !drv_data_oe && !rsp_done,
              "R1", "bus idle in reset",
              int'({drv_cs0_n, drv_cs1_n, drv_rd_n, drv_wr_n, drv_data_oe, rsp_done}), 6'b111100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(drv_cs0_n && drv_cs1_n && drv_rd_n && drv_wr_n && !drv_data_oe && !rsp_done,
              "R1", "bus idle after reset",
              int'({drv_cs0_n, drv_cs1_n, drv_rd_n, drv_wr_n, drv_data_oe, rsp_done}), 6'b111100);
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 2; b++) begin
                for (int a = 0; a < 8; a++) begin
                    run_cycle(w[0], b[0], a[2:0], 16'hA5C3 ^ (16'(a) * 16'h0203) ^ (16'(b) << 12));
                end
            end
        end
        run_cycle(1'b1, 1'b0, 3'd0, 16'hFFFF);
        run_cycle(1'b1, 1'b0, 3'd5, 16'hFF00);
        run_cycle(1'b0, 1'b1, 3'd7, 16'h0000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule